// File: doc/BRIEF.md
# Dual-Tap Reference Divider

This block divides a reference clock by a programmable integer ratio M and serves two phase-detector consumers from the result. A ratio counter makes a near-square waveform with period M. A short binary chain behind it adds waveforms with periods 2M, 4M and 8M. Each consumer has its own 2-bit selector that picks one of these four waveforms.

The auxiliary consumer takes the true phase of its selection, and the main consumer takes the inverted phase. The two detectors therefore act on opposite half-periods and never draw charge-pump current at the same moment. Each consumer gets a strobe that lasts one reference cycle, raised when its tap has a rising edge.

Ratio and selector changes are held back until the ratio counter reaches its terminal count. This keeps the waveforms free of truncated phases. A standby code stops all counting. Leaving standby restarts the count from zero using the inputs presented at that time.

Top module: `dual_ref_divider`

## Requirements
- R1: The ratio M is taken from the 12-bit `ratio_i` and ranges from 3 to 4095. With a selector at code 0, successive strobes on that output are exactly M cycles apart.
- R2: A ratio word of 0, 1 or 2 behaves exactly like a ratio of 3.
- R3: The period-M waveform is low for ceil(M/2) cycles and then high for floor(M/2) cycles. With both selectors at code 0, each main strobe follows the preceding auxiliary strobe by floor(M/2) cycles.
- R4: Selector code s (0, 1, 2, 3) chooses the waveform of period (2^s)·M. Successive strobes on that output are that many cycles apart.
- R5: The auxiliary strobe marks rising edges of its selected waveform. Call edge 0 the first rising clock edge at which reset is released and standby is off. The first auxiliary strobe is high after edge ceil(M/2)+1 for code 0, and after edge (2^(s-1))·M+1 for a code s of 1 to 3.
- R6: The main strobe marks falling edges of its selected waveform, which are the rising edges of its inverted tap. Its first strobe is high after edge (2^s)·M+1.
- R7: Each strobe is high for exactly one clock cycle.
- R8: `pwr_mode_i` = 2'b11 is standby. From the first clock edge that sees this code, both strobes stay low and all counters are held at zero. The codes 2'b00, 2'b01 and 2'b10 all count normally.
- R9: Leaving standby, or releasing reset, restarts the count from zero. It uses the ratio and selector values present at that time, with the first-strobe timing of R5 and R6.
- R10: A change of `ratio_i`, `aux_sel_i` or `main_sel_i` while counting takes effect only at the clock edge where the ratio counter wraps from M-1 to 0.
- R11: While `rst_ni` is low, both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 12 | Division ratio M |
| aux_sel_i | input | 2 | Post-scale selector for the auxiliary (true-phase) consumer |
| main_sel_i | input | 2 | Post-scale selector for the main (inverted-phase) consumer |
| pwr_mode_i | input | 2 | Power mode; 2'b11 selects standby |
| aux_stb_o | output | 1 | One-cycle strobe on the rising edge of the auxiliary tap |
| main_stb_o | output | 1 | One-cycle strobe on the rising edge of the main (inverted) tap |

## Verification
Each strobe comes out one register stage behind the counter state that makes its tap rise. A waveform that rises at count index j therefore shows its strobe after clock edge j+1, counted from edge 0 at release. The bench drives every input on a falling edge and numbers the samples it takes on the following falling edges. It compares the sample indices of the first strobes and the spacing between strobes with the formulas in R3 to R6. For mid-run changes, the expected indices are worked out from the wrap edge at which the new value is loaded, not from the cycle in which it was driven.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   typedef enum logic [1:0] {
      PWR_RUN   = 2'b00,
      PWR_RUN_A = 2'b01,
      PWR_RUN_B = 2'b10,
      PWR_STBY  = 2'b11
   } pwr_mode_e;

   function automatic logic is_standby(input logic [1:0] mode);
      return (mode == PWR_STBY);
   endfunction

endpackage

// File: rtl/refdiv_ratio_ctr.sv
module refdiv_ratio_ctr #(
   parameter int RATIO_W   = 12,
   parameter int MIN_RATIO = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               stby_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               run_o,
   output logic               wrap_o,
   output logic               load_o,
   output logic               mtap_o
);

   localparam logic [RATIO_W-1:0] MIN_V   = RATIO_W'(MIN_RATIO);
   localparam logic [RATIO_W-1:0] MIN_THR = RATIO_W'((MIN_RATIO + 1) / 2);

   initial begin : chk_params
      assert (RATIO_W >= 2) else $error("ratio width too small");
      assert (MIN_RATIO >= 2 && MIN_RATIO < (1 << RATIO_W))
         else $error("minimum ratio out of range");
   end

   logic [RATIO_W-1:0] cnt_q, ratio_q, thr_q;
   logic               run_q;
   logic [RATIO_W-1:0] ratio_clamped;
   logic [RATIO_W:0]   ratio_plus1;
   logic [RATIO_W-1:0] thr_d;
   logic               wrap;

   assign ratio_clamped = (ratio_i < MIN_V) ? MIN_V : ratio_i;
   assign ratio_plus1   = {1'b0, ratio_clamped} + 1'b1;
   assign thr_d         = ratio_plus1[RATIO_W:1];

   assign wrap   = run_q && (cnt_q == ratio_q - 1'b1);
   assign wrap_o = wrap;
   assign load_o = stby_i || !run_q || wrap;
   assign run_o  = run_q;
   // low for ceil(M/2) counts, high for the remaining floor(M/2)
   assign mtap_o = (cnt_q >= thr_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         ratio_q <= MIN_V;
         thr_q   <= MIN_THR;
         run_q   <= 1'b0;
      end else if (stby_i) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         ratio_q <= ratio_clamped;
         thr_q   <= thr_d;
      end else if (!run_q) begin
         cnt_q   <= '0;
         run_q   <= 1'b1;
         ratio_q <= ratio_clamped;
         thr_q   <= thr_d;
      end else if (wrap) begin
         cnt_q   <= '0;
         ratio_q <= ratio_clamped;
         thr_q   <= thr_d;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < ratio_q);

   assert_ratio_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ratio_q >= MIN_V);

   assert_standby_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stby_i |=> (cnt_q == '0) && !run_q);

   assert_ratio_deferred_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && !wrap && !stby_i) |=> $stable(ratio_q));

endmodule

// File: rtl/refdiv_post_chain.sv
module refdiv_post_chain #(
   parameter int NUM_TAPS = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                clear_i,
   input  logic                wrap_i,
   input  logic                mtap_i,
   output logic [NUM_TAPS-1:0] taps_o
);

   localparam int POST_W = NUM_TAPS - 1;

   initial begin : chk_params
      assert (NUM_TAPS >= 2) else $error("need at least two taps");
   end

   logic [POST_W-1:0] post_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      post_q <= '0;
      else if (clear_i) post_q <= '0;
      else if (wrap_i)  post_q <= post_q + 1'b1;
   end

   assign taps_o[0] = mtap_i;
   for (genvar g = 1; g < NUM_TAPS; g++) begin : g_tap
      assign taps_o[g] = post_q[g-1];
   end

   assert_post_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_i && !clear_i) |=> post_q == POST_W'($past(post_q) + 1'b1));

   assert_post_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wrap_i && !clear_i) |=> $stable(post_q));

endmodule

// File: rtl/refdiv_tap_sel.sv
module refdiv_tap_sel #(
   parameter int NUM_TAPS = 4,
   parameter bit INVERT   = 1'b0,
   localparam int SEL_W   = $clog2(NUM_TAPS)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                stby_i,
   input  logic                load_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic [NUM_TAPS-1:0] taps_i,
   output logic                stb_o
);

   initial begin : chk_params
      assert ((1 << SEL_W) == NUM_TAPS) else $error("tap count must be a power of two");
   end

   logic [SEL_W-1:0] sel_q;
   logic             tap, prev_q, stb_q;

   assign tap   = taps_i[sel_q] ^ INVERT;
   assign stb_o = stb_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q  <= '0;
         prev_q <= INVERT;
         stb_q  <= 1'b0;
      end else begin
         if (load_i) sel_q <= sel_i;
         if (stby_i) begin
            prev_q <= INVERT;
            stb_q  <= 1'b0;
         end else begin
            prev_q <= tap;
            stb_q  <= tap & ~prev_q;
         end
      end
   end

   assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_q |=> !stb_q);

   assert_standby_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stby_i |=> !stb_q);

   assert_sel_deferred_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(sel_q));

endmodule

// File: rtl/dual_ref_divider.sv
module dual_ref_divider #(
   parameter int RATIO_W   = 12,
   parameter int MIN_RATIO = 3,
   parameter int NUM_TAPS  = 4,
   localparam int SEL_W    = $clog2(NUM_TAPS)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic [SEL_W-1:0]   aux_sel_i,
   input  logic [SEL_W-1:0]   main_sel_i,
   input  logic [1:0]         pwr_mode_i,
   output logic               aux_stb_o,
   output logic               main_stb_o
);

   localparam int N_CONS = 2;

   logic                stby, run, wrap, load, mtap;
   logic [NUM_TAPS-1:0] taps;
   logic [SEL_W-1:0]    cons_sel [N_CONS];
   logic [N_CONS-1:0]   cons_stb;

   assign stby        = refdiv_pkg::is_standby(pwr_mode_i);
   assign cons_sel[0] = aux_sel_i;
   assign cons_sel[1] = main_sel_i;

   refdiv_ratio_ctr #(
      .RATIO_W  (RATIO_W),
      .MIN_RATIO(MIN_RATIO)
   ) u_ratio (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stby_i (stby),
      .ratio_i(ratio_i),
      .run_o  (run),
      .wrap_o (wrap),
      .load_o (load),
      .mtap_o (mtap)
   );

   refdiv_post_chain #(
      .NUM_TAPS(NUM_TAPS)
   ) u_post (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(stby || !run),
      .wrap_i (wrap),
      .mtap_i (mtap),
      .taps_o (taps)
   );

   // consumer 0 takes the true phase, consumer 1 the inverted phase
   for (genvar g = 0; g < N_CONS; g++) begin : g_cons
      refdiv_tap_sel #(
         .NUM_TAPS(NUM_TAPS),
         .INVERT  (g == 1)
      ) u_sel (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .stby_i(stby),
         .load_i(load),
         .sel_i (cons_sel[g]),
         .taps_i(taps),
         .stb_o (cons_stb[g])
      );
   end

   assign aux_stb_o  = cons_stb[0];
   assign main_stb_o = cons_stb[1];

   assert_reset_quiet_R11: assert property (@(posedge clk_i)
      !rst_ni |-> !aux_stb_o && !main_stb_o);

endmodule

// File: tb/dual_ref_divider_tb.sv
`timescale 1ns/1ps
module dual_ref_divider_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] ratio;
   logic [1:0]  sa, sm, mode;
   logic        aux_stb, main_stb;

   always #2 clk = ~clk;

   dual_ref_divider u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .ratio_i   (ratio),
      .aux_sel_i (sa),
      .main_sel_i(sm),
      .pwr_mode_i(mode),
      .aux_stb_o (aux_stb),
      .main_stb_o(main_stb)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // ratio, aux sel, main sel, run mode, aux first, aux period, main first, main period
   localparam int NV = 9;
   localparam int V_RATIO [NV] = '{3, 4, 5, 7, 10, 2, 0, 9, 100};
   localparam int V_SA    [NV] = '{0, 1, 2, 3, 0,  0, 1, 0, 3};
   localparam int V_SM    [NV] = '{0, 0, 1, 3, 2,  1, 0, 0, 2};
   localparam int V_MODE  [NV] = '{0, 0, 1, 0, 2,  0, 0, 0, 0};
   localparam int V_AF    [NV] = '{3, 5, 11, 29, 6,  3, 4, 6, 401};
   localparam int V_AP    [NV] = '{3, 8, 20, 56, 10, 3, 6, 9, 800};
   localparam int V_MF    [NV] = '{4, 5, 11, 57, 41, 7, 4, 10, 401};
   localparam int V_MP    [NV] = '{3, 4, 10, 56, 40, 6, 3, 9, 400};

   int a_idx [4];
   int m_idx [4];
   int wide;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // sample index s is taken on the falling edge after clock edge s
   task automatic capture(input int len, input int chg_at,
                          input int new_ratio, input int new_sa);
      int na = 0;
      int nm = 0;
      bit pa = 1'b0;
      bit pm = 1'b0;
      for (int k = 0; k < 4; k++) begin
         a_idx[k] = -1;
         m_idx[k] = -1;
      end
      wide = 0;
      for (int s = 0; s < len; s++) begin
         @(posedge clk);
         @(negedge clk);
         if (aux_stb) begin
            if (pa) wide++;
            if (na < 4) a_idx[na] = s;
            na++;
         end
         if (main_stb) begin
            if (pm) wide++;
            if (nm < 4) m_idx[nm] = s;
            nm++;
         end
         pa = aux_stb;
         pm = main_stb;
         if (s == chg_at) begin
            if (new_ratio >= 0) ratio = 12'(new_ratio);
            if (new_sa >= 0)    sa    = 2'(new_sa);
         end
      end
   endtask

   task automatic enter_standby(input int cycles);
      mode = 2'b11;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         check(!aux_stb && !main_stb, "R8", "strobe during standby",
               int'(aux_stb) + int'(main_stb), 0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main_seq
      rst_n = 1'b0;
      ratio = 12'd6;
      sa    = 2'd0;
      sm    = 2'd0;
      mode  = 2'b00;

      // R11: quiet during reset
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         check(!aux_stb && !main_stb, "R11", "strobe in reset",
               int'(aux_stb) + int'(main_stb), 0);
      end
      rst_n = 1'b1;
      // R9: restart after reset with M=6
      capture(12, -1, -1, -1);
      check(a_idx[0] == 4, "R9", "aux first after reset", a_idx[0], 4);
      check(m_idx[0] == 7, "R9", "main first after reset", m_idx[0], 7);

      // table walk
      for (int i = 0; i < NV; i++) begin
         int len;
         ratio = 12'(V_RATIO[i]);
         sa    = 2'(V_SA[i]);
         sm    = 2'(V_SM[i]);
         enter_standby(6);
         mode  = 2'(V_MODE[i]);
         len   = V_AF[i] + V_AP[i];
         if (V_MF[i] + V_MP[i] > len) len = V_MF[i] + V_MP[i];
         capture(len + 3, -1, -1, -1);
         // R5 / R3 / R8 (run codes) / R2 (clamped entries)
         check(a_idx[0] == V_AF[i], "R5", $sformatf("aux first v%0d", i), a_idx[0], V_AF[i]);
         check(a_idx[1] - a_idx[0] == V_AP[i], "R4", $sformatf("aux period v%0d", i),
               a_idx[1] - a_idx[0], V_AP[i]);
         check(m_idx[0] == V_MF[i], "R6", $sformatf("main first v%0d", i), m_idx[0], V_MF[i]);
         check(m_idx[1] - m_idx[0] == V_MP[i], "R4", $sformatf("main period v%0d", i),
               m_idx[1] - m_idx[0], V_MP[i]);
         check(wide == 0, "R7", $sformatf("strobe wider than one cycle v%0d", i), wide, 0);
      end

      // R2: ratio 2 and 0 measured as period 3 (table rows 5 and 6, re-stated)
      ratio = 12'd1; sa = 2'd0; sm = 2'd0;
      enter_standby(3);
      mode = 2'b00;
      capture(12, -1, -1, -1);
      check(a_idx[1] - a_idx[0] == 3, "R2", "ratio 1 period", a_idx[1] - a_idx[0], 3);

      // R3: duty via aux-to-main offset, M=9
      ratio = 12'd9;
      enter_standby(3);
      mode = 2'b00;
      capture(22, -1, -1, -1);
      check(m_idx[0] - a_idx[0] == 4, "R3", "high phase M=9", m_idx[0] - a_idx[0], 4);
      check(m_idx[1] - a_idx[1] == 4, "R3", "high phase M=9 again", m_idx[1] - a_idx[1], 4);

      // R10: ratio change 5 -> 8 after sample 7, loaded at the wrap on edge 10
      ratio = 12'd5; sa = 2'd0; sm = 2'd0;
      enter_standby(3);
      mode = 2'b00;
      capture(25, 7, 8, -1);
      check(a_idx[1] == 9,  "R10", "aux strobe before wrap", a_idx[1], 9);
      check(a_idx[2] == 15, "R10", "aux strobe after new ratio", a_idx[2], 15);
      check(m_idx[1] == 11, "R10", "main strobe at old wrap", m_idx[1], 11);
      check(m_idx[2] == 19, "R10", "main strobe at new wrap", m_idx[2], 19);

      // R10: aux select 0 -> 1 after sample 4, M=4, loaded at edge 8
      ratio = 12'd4; sa = 2'd0; sm = 2'd0;
      enter_standby(3);
      mode = 2'b00;
      capture(24, 4, -1, 1);
      check(a_idx[1] == 7,  "R10", "aux old select kept", a_idx[1], 7);
      check(a_idx[2] == 13, "R10", "aux new select first", a_idx[2], 13);
      check(a_idx[3] == 21, "R10", "aux new select period", a_idx[3], 21);
      check(m_idx[1] == 9,  "R10", "main unaffected", m_idx[1], 9);

      // R8: long standby mid-run after frequent strobes
      ratio = 12'd3; sa = 2'd0; sm = 2'd0;
      enter_standby(3);
      mode = 2'b00;
      capture(10, -1, -1, -1);
      enter_standby(40);

      // R1: largest ratio
      ratio = 12'd4095; sa = 2'd0; sm = 2'd0;
      mode = 2'b00;
      capture(6148, -1, -1, -1);
      check(a_idx[0] == 2049, "R1", "aux first M=4095", a_idx[0], 2049);
      check(a_idx[1] == 6144, "R1", "aux second M=4095", a_idx[1], 6144);
      check(m_idx[0] == 4096, "R1", "main first M=4095", m_idx[0], 4096);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule